// File: doc/BRIEF.md
# Validation Event Countdown Scheduler

This block holds four independent countdown timers. Each one raises a system-level event when its time runs out: a reset request, an interrupt request, a fast interrupt request or a debug request. Software sets the wait time by writing the two's-complement negative of the wanted cycle count into a timer through a value-write port. It then starts the timer through a write-only command port. A running timer counts up by one on every clock. When it rolls over from all-ones to zero, it latches an event flag and drives its event output.

Three of the timers share their storage with performance-monitor counters. The flag of each of these three is cleared by setting its own bit in a monitor-control write, which hands the counter back to monitoring. The debug timer has no monitor role, so a stop command clears its flag. Any mix of the four timers may run, and may fire in the same cycle.

Top module: `vsched_top`

## Requirements
- R1: After a synchronous active-high reset, all four counts read zero, no timer is running, the three active-low event outputs are high and the debug event output is low.
- R2: A running timer adds exactly one to its count on every clock, and rolls over from 0xFFFFFFFF to 0x00000000.
- R3: A value write with selector 0 (reset timer), 1 (interrupt), 2 (fast interrupt) or 3 (debug) replaces that count on the next edge. It takes priority over an increment in the same cycle.
- R4: A start command, which is a command write with the start bit at 1, leaves the count unchanged on the edge that captures it. The first increment comes one clock later.
- R5: A timer loaded with minus N and then started fires N clocks after the start edge. Firing drives the output low for reset, interrupt and fast interrupt, and high for debug. The output holds while the timer runs and its flag stays set.
- R6: A monitor-control write with bit 10 clears the reset flag, bit 9 clears the fast-interrupt flag and bit 8 clears the interrupt flag. Other bits leave the flags alone. A rollover in the same cycle as a clear wins, so the flag stays set.
- R7: A stop command, which is a command write with the start bit at 0, halts counting from the next edge and takes the event output inactive. The flags of the reset, interrupt and fast-interrupt timers survive a stop and show again on restart. The debug flag is cleared by the stop.
- R8: The command port reads back as 0x00000000 at all times.
- R9: Timers started in different cycles but due on the same edge all fire together on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| val_wr_en | input | 1 | Count value write strobe |
| val_wr_sel | input | 2 | Timer selected by the value write |
| val_wr_data | input | 32 | Count value to load |
| ops_wr_en | input | 1 | Command write strobe |
| ops_wr_sel | input | 2 | Timer selected by the command |
| ops_wr_start | input | 1 | 1 = start, 0 = stop |
| ops_rd_data | output | 32 | Read value of the command port, always zero |
| pmc_wr_en | input | 1 | Monitor-control write strobe |
| pmc_wr_data | input | 32 | Monitor-control write data (bits 10, 9, 8 clear flags) |
| evt_rst_n | output | 1 | Reset event, active low |
| evt_irq_n | output | 1 | Interrupt event, active low |
| evt_fiq_n | output | 1 | Fast interrupt event, active low |
| evt_dbg | output | 1 | Debug request event, active high |
| cnt_rst | output | 32 | Reset timer count |
| cnt_irq | output | 32 | Interrupt timer count |
| cnt_fiq | output | 32 | Fast interrupt timer count |
| cnt_dbg | output | 32 | Debug timer count |

## Verification
Two cases can fall in the same cycle. The first is a rollover together with a monitor-control clear of the same timer. The bench loads the fast-interrupt timer with minus two, starts it, and lands the bit-9 clear exactly on the rollover edge. The flag must then stay set and the output stay low until a second clear. The second case is several timers firing together. Three timers are loaded with minus five, minus four and minus three and started on consecutive edges. All three outputs must be inactive one edge before the common due edge and active right after it.

// File: rtl/vsched_pkg.sv
package vsched_pkg;
    localparam int NUM_CTR = 4;
    localparam int CTR_W   = 32;
    localparam int SEL_W   = $clog2(NUM_CTR);
    localparam int PMC_W   = 32;

    typedef enum logic [SEL_W-1:0] {
        CTR_RST = 2'd0,
        CTR_IRQ = 2'd1,
        CTR_FIQ = 2'd2,
        CTR_DBG = 2'd3
    } ctr_id_e;

    // Monitor-control bit that clears each shared timer's flag.
    function automatic int clr_bit(int idx);
        case (idx)
            0:       return 10;
            1:       return 8;
            2:       return 9;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/vsched_dec.sv
module vsched_dec #(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic          en,
    input  logic [SW-1:0] sel,
    output logic [N-1:0]  oh
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            oh[i] = en && (sel == SW'(i));
        end
    end
endmodule

// File: rtl/vsched_ctr.sv
module vsched_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         start,
    input  logic         stop,
    input  logic         flag_clr,
    output logic [W-1:0] cnt_o,
    output logic         run_o,
    output logic         flag_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
        logic         flag;
    } state_t;

    state_t s_d, s_q;
    logic   wrap;

    always_comb begin
        s_d  = s_q;
        wrap = s_q.run && !load && (s_q.cnt == ALL_ONES);

        if (start) begin
            s_d.run = 1'b1;
        end else if (stop) begin
            s_d.run = 1'b0;
        end

        if (load) begin
            s_d.cnt = load_val;
        end else if (s_q.run) begin
            s_d.cnt = s_q.cnt + W'(1);
        end

        // rollover beats a clear in the same cycle
        if (wrap) begin
            s_d.flag = 1'b1;
        end else if (flag_clr) begin
            s_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o  = s_q.cnt;
    assign run_o  = s_q.run;
    assign flag_o = s_q.flag;
endmodule

// File: rtl/vsched_top.sv
module vsched_top
    import vsched_pkg::*;
#(
    parameter int CNT_W = CTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             val_wr_en,
    input  logic [SEL_W-1:0] val_wr_sel,
    input  logic [CNT_W-1:0] val_wr_data,
    input  logic             ops_wr_en,
    input  logic [SEL_W-1:0] ops_wr_sel,
    input  logic             ops_wr_start,
    output logic [CNT_W-1:0] ops_rd_data,
    input  logic             pmc_wr_en,
    input  logic [PMC_W-1:0] pmc_wr_data,
    output logic             evt_rst_n,
    output logic             evt_irq_n,
    output logic             evt_fiq_n,
    output logic             evt_dbg,
    output logic [CNT_W-1:0] cnt_rst,
    output logic [CNT_W-1:0] cnt_irq,
    output logic [CNT_W-1:0] cnt_fiq,
    output logic [CNT_W-1:0] cnt_dbg
);
    logic [NUM_CTR-1:0] load_oh, ops_oh, start_vec, stop_vec, clr_vec;
    logic [NUM_CTR-1:0] run_vec, flag_vec, evt_vec;
    logic [CNT_W-1:0]   cnt_arr [NUM_CTR];

    vsched_dec #(.N(NUM_CTR), .SW(SEL_W)) u_val_dec (
        .en (val_wr_en),
        .sel(val_wr_sel),
        .oh (load_oh)
    );

    vsched_dec #(.N(NUM_CTR), .SW(SEL_W)) u_ops_dec (
        .en (ops_wr_en),
        .sel(ops_wr_sel),
        .oh (ops_oh)
    );

    assign start_vec = ops_oh & {NUM_CTR{ops_wr_start}};
    assign stop_vec  = ops_oh & {NUM_CTR{!ops_wr_start}};

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        if (g == int'(CTR_DBG)) begin : g_stop_clr
            assign clr_vec[g] = stop_vec[g];
        end else begin : g_pmc_clr
            assign clr_vec[g] = pmc_wr_en && pmc_wr_data[clr_bit(g)];
        end

        vsched_ctr #(.W(CNT_W)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .load    (load_oh[g]),
            .load_val(val_wr_data),
            .start   (start_vec[g]),
            .stop    (stop_vec[g]),
            .flag_clr(clr_vec[g]),
            .cnt_o   (cnt_arr[g]),
            .run_o   (run_vec[g]),
            .flag_o  (flag_vec[g])
        );

        assign evt_vec[g] = flag_vec[g] && run_vec[g];
    end

    assign evt_rst_n   = !evt_vec[CTR_RST];
    assign evt_irq_n   = !evt_vec[CTR_IRQ];
    assign evt_fiq_n   = !evt_vec[CTR_FIQ];
    assign evt_dbg     = evt_vec[CTR_DBG];
    assign cnt_rst     = cnt_arr[CTR_RST];
    assign cnt_irq     = cnt_arr[CTR_IRQ];
    assign cnt_fiq     = cnt_arr[CTR_FIQ];
    assign cnt_dbg     = cnt_arr[CTR_DBG];
    assign ops_rd_data = '0;
endmodule

// File: rtl/vsched_checker.sv
module vsched_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         val_wr_en,
    input logic [1:0]   val_wr_sel,
    input logic [W-1:0] val_wr_data,
    input logic         ops_wr_en,
    input logic [1:0]   ops_wr_sel,
    input logic         ops_wr_start,
    input logic         pmc_wr_en,
    input logic [31:0]  pmc_wr_data,
    input logic         evt_rst_n,
    input logic         evt_irq_n,
    input logic         evt_fiq_n,
    input logic         evt_dbg,
    input logic [W-1:0] cnt_rst,
    input logic [W-1:0] cnt_irq,
    input logic [W-1:0] cnt_fiq,
    input logic [W-1:0] cnt_dbg,
    input logic [3:0]   run_vec
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] c [4];
    logic [3:0]   act, ld, st, sp, wr;

    assign c[0]   = cnt_rst;
    assign c[1]   = cnt_irq;
    assign c[2]   = cnt_fiq;
    assign c[3]   = cnt_dbg;
    assign act    = {evt_dbg, !evt_fiq_n, !evt_irq_n, !evt_rst_n};

    for (genvar i = 0; i < 4; i++) begin : g_chk
        assign ld[i] = val_wr_en && (val_wr_sel == 2'(i));
        assign st[i] = ops_wr_en && ops_wr_start && (ops_wr_sel == 2'(i));
        assign sp[i] = ops_wr_en && !ops_wr_start && (ops_wr_sel == 2'(i));
        assign wr[i] = run_vec[i] && !ld[i] && (c[i] == ALL_ONES);

        assert_step_R2: assert property (@(posedge clk) disable iff (rst)
            (run_vec[i] && !ld[i]) |=> (c[i] == $past(c[i]) + W'(1)));

        assert_load_R3: assert property (@(posedge clk) disable iff (rst)
            ld[i] |=> (c[i] == $past(val_wr_data)));

        assert_start_delay_R4: assert property (@(posedge clk) disable iff (rst)
            (st[i] && !run_vec[i] && !ld[i]) |=> $stable(c[i]));

        assert_fire_R5: assert property (@(posedge clk) disable iff (rst)
            (wr[i] && !sp[i]) |=> act[i]);
    end

    assert_reset_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (pmc_wr_en && pmc_wr_data[10] && !wr[0]) |=> evt_rst_n);

    assert_dbg_stop_R7: assert property (@(posedge clk) disable iff (rst)
        sp[3] |=> !evt_dbg);
endmodule

bind vsched_top vsched_checker #(.W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .val_wr_en   (val_wr_en),
    .val_wr_sel  (val_wr_sel),
    .val_wr_data (val_wr_data),
    .ops_wr_en   (ops_wr_en),
    .ops_wr_sel  (ops_wr_sel),
    .ops_wr_start(ops_wr_start),
    .pmc_wr_en   (pmc_wr_en),
    .pmc_wr_data (pmc_wr_data),
    .evt_rst_n   (evt_rst_n),
    .evt_irq_n   (evt_irq_n),
    .evt_fiq_n   (evt_fiq_n),
    .evt_dbg     (evt_dbg),
    .cnt_rst     (cnt_rst),
    .cnt_irq     (cnt_irq),
    .cnt_fiq     (cnt_fiq),
    .cnt_dbg     (cnt_dbg),
    .run_vec     (run_vec)
);

// File: tb/tb_vsched_top.sv
`timescale 1ns/1ps
module tb_vsched_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        val_wr_en = 1'b0;
    logic [1:0]  val_wr_sel = '0;
    logic [31:0] val_wr_data = '0;
    logic        ops_wr_en = 1'b0;
    logic [1:0]  ops_wr_sel = '0;
    logic        ops_wr_start = 1'b0;
    logic [31:0] ops_rd_data;
    logic        pmc_wr_en = 1'b0;
    logic [31:0] pmc_wr_data = '0;
    logic        evt_rst_n, evt_irq_n, evt_fiq_n, evt_dbg;
    logic [31:0] cnt_rst, cnt_irq, cnt_fiq, cnt_dbg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vsched_top dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic val_write(logic [1:0] sel, logic [31:0] data);
        val_wr_en = 1'b1; val_wr_sel = sel; val_wr_data = data;
        @(negedge clk);
        val_wr_en = 1'b0;
    endtask

    task automatic ops_write(logic [1:0] sel, logic start);
        ops_wr_en = 1'b1; ops_wr_sel = sel; ops_wr_start = start;
        @(negedge clk);
        ops_wr_en = 1'b0;
    endtask

    task automatic pmc_write(logic [31:0] data);
        pmc_wr_en = 1'b1; pmc_wr_data = data;
        @(negedge clk);
        pmc_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cnt_rst", cnt_rst, 0);
        chk("R1 cnt_irq", cnt_irq, 0);
        chk("R1 cnt_fiq", cnt_fiq, 0);
        chk("R1 cnt_dbg", cnt_dbg, 0);
        chk("R1 events", {28'd0, evt_dbg, evt_fiq_n, evt_irq_n, evt_rst_n}, 32'h7);
        chk("R8 read zero", ops_rd_data, 0);
    endtask

    task automatic t_wrap();
        val_write(2'd0, -32'sd5);
        idle(2);
        ops_write(2'd0, 1'b1);
        chk("R4 no step on start edge", cnt_rst, 32'hFFFF_FFFB);
        idle(1);
        chk("R2 first step", cnt_rst, 32'hFFFF_FFFC);
        idle(3);
        chk("R2 at all-ones", cnt_rst, 32'hFFFF_FFFF);
        chk("R5 not yet", {31'd0, evt_rst_n}, 1);
        idle(1);
        chk("R2 rollover", cnt_rst, 32'h0);
        chk("R5 fired", {31'd0, evt_rst_n}, 0);
        idle(2);
        chk("R5 held", {31'd0, evt_rst_n}, 0);
    endtask

    task automatic t_pmc();
        pmc_write(32'hFFFF_F8FF);
        chk("R6 other bits ignored", {31'd0, evt_rst_n}, 0);
        pmc_write(32'h0000_0400);
        chk("R6 bit10 clears", {31'd0, evt_rst_n}, 1);
    endtask

    task automatic t_load_running();
        val_write(2'd0, 32'h0000_1234);
        chk("R3 load over step", cnt_rst, 32'h0000_1234);
        idle(1);
        chk("R3 resumes", cnt_rst, 32'h0000_1235);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        v = cnt_rst;
        ops_write(2'd0, 1'b0);
        chk("R7 last step", cnt_rst, v + 1);
        idle(3);
        chk("R7 halted", cnt_rst, v + 1);
    endtask

    task automatic t_simul();
        val_write(2'd1, -32'sd5);
        val_write(2'd2, -32'sd4);
        val_write(2'd3, -32'sd3);
        idle(2);
        ops_write(2'd1, 1'b1);
        ops_write(2'd2, 1'b1);
        ops_write(2'd3, 1'b1);
        idle(2);
        chk("R9 none early", {29'd0, evt_dbg, evt_fiq_n, evt_irq_n}, 32'h3);
        chk("R9 irq at all-ones", cnt_irq, 32'hFFFF_FFFF);
        idle(1);
        chk("R9 all together", {29'd0, evt_dbg, evt_fiq_n, evt_irq_n}, 32'h4);
    endtask

    task automatic t_stop_flag();
        ops_write(2'd1, 1'b0);
        chk("R7 stop hides irq", {31'd0, evt_irq_n}, 1);
        ops_write(2'd1, 1'b1);
        chk("R7 irq flag survives", {31'd0, evt_irq_n}, 0);
        pmc_write(32'h0000_0100);
        chk("R6 bit8 clears irq", {31'd0, evt_irq_n}, 1);
        ops_write(2'd3, 1'b0);
        chk("R7 dbg stop", {31'd0, evt_dbg}, 0);
        ops_write(2'd3, 1'b1);
        chk("R7 dbg flag cleared", {31'd0, evt_dbg}, 0);
        ops_write(2'd1, 1'b0);
        ops_write(2'd3, 1'b0);
    endtask

    task automatic t_collide();
        ops_write(2'd2, 1'b0);
        pmc_write(32'h0000_0200);
        chk("R6 bit9 clears fiq", {31'd0, evt_fiq_n}, 1);
        val_write(2'd2, -32'sd2);
        idle(2);
        ops_write(2'd2, 1'b1);
        idle(1);
        pmc_write(32'h0000_0200);
        chk("R6 rollover beats clear", {31'd0, evt_fiq_n}, 0);
        chk("R2 fiq rolled", cnt_fiq, 32'h0);
        pmc_write(32'h0000_0200);
        chk("R6 later clear", {31'd0, evt_fiq_n}, 1);
        chk("R8 read zero after use", ops_rd_data, 0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_wrap();
        t_pmc();
        t_load_running();
        t_stop();
        t_simul();
        t_stop_flag();
        t_collide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule